// File: doc/BRIEF.md
# Dual-Pointer Return Address Stack

This block holds return addresses for calls made while a core executes straight out of shared main memory. One 256-entry memory serves two independent stack pointers, A and B. A call through either pointer pushes the address of the following instruction together with a bit that records whether the caller was running from local memory. A return through the same pointer pops that entry and yields the jump target and a flag that tells the sequencer whether to drop back into local execution.

A return can modify the stack in one of two ways. In offset mode a signed immediate, scaled by four, is added to the popped address. In adjust mode the same immediate first moves the pointer, which discards stack frames, and then the pop happens. A third call form bypasses the stack and writes the return address to a fixed register through a one-port write interface. Its matching return jumps to the address read back from that register. When requested, the block reports pointer wrap-around and A/B pointer collision as carry and zero flags. One operation is accepted per clock, and all results appear on the cycle after the request.

Top module: `rasx_dual_stack`

## Requirements
- R1: After reset, `sp_a` is 0 and `sp_b` is 128, and `ret_valid`, `flag_c_we`, `flag_z_we` and `link_we` are all 0.
- R2: A call via A (`req_op`=1) decrements `sp_a` by one, modulo 256, on the next cycle. It stores {`req_local`, `req_addr`} at the new `sp_a` and leaves `sp_b` unchanged.
- R3: A call via B (`req_op`=2) behaves like R2, using and updating `sp_b` and leaving `sp_a` unchanged.
- R4: A return via A (`req_op`=4) or via B (`req_op`=5) with `req_adjust`=0 reads the entry at the current pointer and then increments that pointer. On the next cycle `ret_valid` pulses, and `ret_target` is the stored address plus 4 × `req_imm`, where `req_imm` is a 9-bit two's-complement value and the sum wraps at 20 bits.
- R5: A return with `req_adjust`=1 first adds the signed `req_imm` to the pointer and pops the entry at that location. The pointer ends at old + imm + 1, modulo 256, and `ret_target` is the stored address with no offset.
- R6: `ret_to_local` on a stack return equals the `req_local` bit recorded by the call that pushed the popped entry.
- R7: When `req_wr_c` is set on a stack call or return, `flag_c_we` pulses on the next cycle. `flag_c` is then 1 exactly when the exact integer result of the pointer update falls outside 0..255. When `flag_c_we` stays 0, `flag_c` keeps its value.
- R8: When `req_wr_z` is set on a stack call or return, `flag_z_we` pulses on the next cycle. `flag_z` is then 1 exactly when `sp_a` equals `sp_b` after the update.
- R9: A link call (`req_op`=3) pulses `link_we` on the next cycle, with `link_waddr` = 0x1F0 and `link_wdata` = `req_addr`. Both pointers stay unchanged. Any requested C or Z flag is written as 0.
- R10: A link return (`req_op`=6) pulses `ret_valid`, with `ret_target` = `req_addr` + 4 × `req_imm`. `ret_to_local` equals the `req_local` of the most recent link call.
- R11: `req_op` values 0 (idle) and 7 (reserved) change neither pointer and produce no `ret_valid`, `flag_c_we`, `flag_z_we` or `link_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 3 | Operation code: 0 idle, 1 call A, 2 call B, 3 link call, 4 return A, 5 return B, 6 link return, 7 reserved |
| req_addr | input | 20 | Next-instruction address for calls, or link register contents for a link return |
| req_local | input | 1 | Caller was running from local memory |
| req_imm | input | 9 | Signed immediate for a return |
| req_adjust | input | 1 | 1: move the pointer by the immediate before popping; 0: add 4 × immediate to the target |
| req_wr_c | input | 1 | Request a carry (wrap) flag write |
| req_wr_z | input | 1 | Request a zero (collision) flag write |
| ret_valid | output | 1 | Return target valid this cycle |
| ret_target | output | 20 | Return jump address |
| ret_to_local | output | 1 | Return should switch back to local execution |
| flag_c_we | output | 1 | Carry flag write strobe |
| flag_c | output | 1 | Wrap indication |
| flag_z_we | output | 1 | Zero flag write strobe |
| flag_z | output | 1 | Collision indication |
| link_we | output | 1 | Link register write strobe |
| link_waddr | output | 9 | Link register location (0x1F0) |
| link_wdata | output | 20 | Return address written to the link register |
| sp_a | output | 8 | Current pointer A |
| sp_b | output | 8 | Current pointer B |

## Verification
The hardest state to reach is a collision. The two pointers start half the memory apart, so A has to be pushed 128 times in a row before it lands on B. The stimulus therefore runs a long burst of calls via A with the Z request set, and it checks that Z stays clear until the very last push. Straight after that, an adjust-mode return with a large positive immediate carries the pointer past the top of the memory. This exercises wrap reporting on a pop, collision on a pop, and the read of a slot that was filled through the other pointer, all in one operation.

// File: rtl/rasx_pkg.sv
package rasx_pkg;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_CALL_A    = 3'd1,
        OP_CALL_B    = 3'd2,
        OP_CALL_LINK = 3'd3,
        OP_RET_A     = 3'd4,
        OP_RET_B     = 3'd5,
        OP_RET_LINK  = 3'd6,
        OP_RSVD      = 3'd7
    } rasx_op_e;

endpackage

// File: rtl/rasx_ptr_unit.sv
// Pointer arithmetic for one stack pointer: pre-decrement on push,
// optional pre-adjust then post-increment on pop, wrap detection.
module rasx_ptr_unit #(
    parameter int PTR_W = 8,
    parameter int IMM_W = 9
) (
    input  logic [PTR_W-1:0] sp,
    input  logic             push,
    input  logic             pop,
    input  logic             adjust,
    input  logic [IMM_W-1:0] imm,
    output logic [PTR_W-1:0] sp_next,
    output logic [PTR_W-1:0] idx,
    output logic             wrap
);
    localparam int EXT_W = ((PTR_W > IMM_W) ? PTR_W : IMM_W) + 2;

    logic [EXT_W-1:0] ext_sp;
    logic [EXT_W-1:0] ext_imm;
    logic [EXT_W-1:0] base;
    logic [EXT_W-1:0] after;

    assign ext_sp  = {{(EXT_W-PTR_W){1'b0}}, sp};
    assign ext_imm = {{(EXT_W-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        base  = ext_sp;
        after = ext_sp;
        idx   = sp;
        if (push) begin
            after = ext_sp - EXT_W'(1);
            idx   = after[PTR_W-1:0];
        end else if (pop) begin
            base  = adjust ? (ext_sp + ext_imm) : ext_sp;
            idx   = base[PTR_W-1:0];
            after = base + EXT_W'(1);
        end
        sp_next = after[PTR_W-1:0];
        // any bit above the pointer range means the exact result left 0..DEPTH-1
        wrap    = |after[EXT_W-1:PTR_W];
    end
endmodule

// File: rtl/rasx_store.sv
// Shared entry memory: one synchronous write port, one combinational read port.
module rasx_store #(
    parameter int ENT_W = 21,
    parameter int PTR_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] addr,
    input  logic [ENT_W-1:0] wdata,
    output logic [ENT_W-1:0] rdata
);
    localparam int DEPTH = 1 << PTR_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rasx_dual_stack.sv
module rasx_dual_stack #(
    parameter int          ADDR_W   = 20,
    parameter int          PTR_W    = 8,
    parameter int          IMM_W    = 9,
    parameter int          B_INIT   = 128,
    parameter logic [8:0]  LINK_IDX = 9'h1F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_local,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic              req_adjust,
    input  logic              req_wr_c,
    input  logic              req_wr_z,
    output logic              ret_valid,
    output logic [ADDR_W-1:0] ret_target,
    output logic              ret_to_local,
    output logic              flag_c_we,
    output logic              flag_c,
    output logic              flag_z_we,
    output logic              flag_z,
    output logic              link_we,
    output logic [8:0]        link_waddr,
    output logic [ADDR_W-1:0] link_wdata,
    output logic [PTR_W-1:0]  sp_a,
    output logic [PTR_W-1:0]  sp_b
);
    import rasx_pkg::*;

    localparam int ENT_W = ADDR_W + 1;
    localparam int NPTR  = 2;

    typedef struct packed {
        logic [NPTR-1:0][PTR_W-1:0] sp;
        logic                       ret_valid;
        logic [ADDR_W-1:0]          ret_target;
        logic                       ret_local;
        logic                       c_we;
        logic                       c;
        logic                       z_we;
        logic                       z;
        logic                       link_we;
        logic [ADDR_W-1:0]          link_data;
        logic                       link_local;
    } state_t;

    state_t st_d, st_q;

    rasx_op_e op;
    assign op = rasx_op_e'(req_op);

    logic [NPTR-1:0]            push_sel;
    logic [NPTR-1:0]            pop_sel;
    logic [NPTR-1:0][PTR_W-1:0] nxt_sp;
    logic [NPTR-1:0][PTR_W-1:0] acc_idx;
    logic [NPTR-1:0]            wrp;

    assign push_sel = {op == OP_CALL_B, op == OP_CALL_A};
    assign pop_sel  = {op == OP_RET_B,  op == OP_RET_A};

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        rasx_ptr_unit #(
            .PTR_W(PTR_W),
            .IMM_W(IMM_W)
        ) i_ptr (
            .sp     (st_q.sp[g]),
            .push   (push_sel[g]),
            .pop    (pop_sel[g]),
            .adjust (req_adjust),
            .imm    (req_imm),
            .sp_next(nxt_sp[g]),
            .idx    (acc_idx[g]),
            .wrap   (wrp[g])
        );
    end

    logic              use_b;
    logic              mem_we;
    logic [PTR_W-1:0]  mem_addr;
    logic [ENT_W-1:0]  mem_rdata;
    logic [ADDR_W-1:0] offset;
    logic              stack_op;
    logic              link_op;

    assign use_b    = push_sel[1] | pop_sel[1];
    assign mem_we   = |push_sel;
    assign mem_addr = use_b ? acc_idx[1] : acc_idx[0];
    assign offset   = {{(ADDR_W-IMM_W-2){req_imm[IMM_W-1]}}, req_imm, 2'b00};
    assign stack_op = (|push_sel) | (|pop_sel);
    assign link_op  = (op == OP_CALL_LINK) | (op == OP_RET_LINK);

    rasx_store #(
        .ENT_W(ENT_W),
        .PTR_W(PTR_W)
    ) i_store (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata({req_local, req_addr}),
        .rdata(mem_rdata)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sp        = nxt_sp;
        st_d.ret_valid = 1'b0;
        st_d.c_we      = 1'b0;
        st_d.z_we      = 1'b0;
        st_d.link_we   = 1'b0;

        if (stack_op) begin
            if (req_wr_c) begin
                st_d.c_we = 1'b1;
                st_d.c    = |wrp;
            end
            if (req_wr_z) begin
                st_d.z_we = 1'b1;
                st_d.z    = (nxt_sp[0] == nxt_sp[1]);
            end
        end else if (link_op) begin
            if (req_wr_c) begin
                st_d.c_we = 1'b1;
                st_d.c    = 1'b0;
            end
            if (req_wr_z) begin
                st_d.z_we = 1'b1;
                st_d.z    = 1'b0;
            end
        end

        if (|pop_sel) begin
            st_d.ret_valid  = 1'b1;
            st_d.ret_local  = mem_rdata[ADDR_W];
            st_d.ret_target = mem_rdata[ADDR_W-1:0]
                            + (req_adjust ? '0 : offset);
        end

        if (op == OP_CALL_LINK) begin
            st_d.link_we    = 1'b1;
            st_d.link_data  = req_addr;
            st_d.link_local = req_local;
        end

        if (op == OP_RET_LINK) begin
            st_d.ret_valid  = 1'b1;
            st_d.ret_target = req_addr + offset;
            st_d.ret_local  = st_q.link_local;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.sp[1] <= PTR_W'(B_INIT);
        end else begin
            st_q <= st_d;
        end
    end

    assign ret_valid    = st_q.ret_valid;
    assign ret_target   = st_q.ret_target;
    assign ret_to_local = st_q.ret_local;
    assign flag_c_we    = st_q.c_we;
    assign flag_c       = st_q.c;
    assign flag_z_we    = st_q.z_we;
    assign flag_z       = st_q.z;
    assign link_we      = st_q.link_we;
    assign link_waddr   = LINK_IDX;
    assign link_wdata   = st_q.link_data;
    assign sp_a         = st_q.sp[0];
    assign sp_b         = st_q.sp[1];
endmodule

// File: rtl/rasx_dual_stack_chk.sv
module rasx_dual_stack_chk #(
    parameter int ADDR_W = 20,
    parameter int PTR_W  = 8,
    parameter int IMM_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_local,
    input logic [IMM_W-1:0]  req_imm,
    input logic              req_adjust,
    input logic              req_wr_c,
    input logic              req_wr_z,
    input logic              ret_valid,
    input logic [ADDR_W-1:0] ret_target,
    input logic              ret_to_local,
    input logic              flag_c_we,
    input logic              flag_c,
    input logic              flag_z_we,
    input logic              flag_z,
    input logic              link_we,
    input logic [8:0]        link_waddr,
    input logic [ADDR_W-1:0] link_wdata,
    input logic [PTR_W-1:0]  sp_a,
    input logic [PTR_W-1:0]  sp_b
);
    a_r2_call_a_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd1) |=> (sp_a == $past(sp_a) - PTR_W'(1)) && (sp_b == $past(sp_b)));

    a_r3_call_b_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd2) |=> (sp_b == $past(sp_b) - PTR_W'(1)) && (sp_a == $past(sp_a)));

    a_r4_pop_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd4 && !req_adjust) |=> ret_valid && (sp_a == $past(sp_a) + PTR_W'(1)));

    a_r7_push_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd1 && sp_a == '0 && req_wr_c) |=> flag_c_we && flag_c);

    a_r7_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_c_we |=> (flag_c_we || $stable(flag_c)));

    a_r8_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr_z && (req_op == 3'd1 || req_op == 3'd2 || req_op == 3'd4 || req_op == 3'd5))
        |=> flag_z_we && (flag_z == (sp_a == sp_b)));

    a_r9_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd3) |=> link_we && (link_wdata == $past(req_addr))
                             && $stable(sp_a) && $stable(sp_b));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'd0 || req_op == 3'd7) |=> !ret_valid && !link_we && !flag_c_we
                                             && !flag_z_we && $stable(sp_a) && $stable(sp_b));
endmodule

bind rasx_dual_stack rasx_dual_stack_chk #(
    .ADDR_W(ADDR_W),
    .PTR_W (PTR_W),
    .IMM_W (IMM_W)
) i_chk (.*);

// File: tb/test_rasx_dual_stack.sv
module test_rasx_dual_stack;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] addr;
        logic        loc;
        logic [8:0]  imm;
        logic        adj;
        logic        wc;
        logic        wz;
        logic        rv;
        logic [19:0] tgt;
        logic        eloc;
        logic [7:0]  spa;
        logic [7:0]  spb;
        logic        cwe;
        logic        c;
        logic        zwe;
        logic        z;
        logic        lwe;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 20'h00100, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b0, 8'hFF, 8'h80, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},
        '{3'd1, 20'h00204, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0, 1'b0, 20'h00000, 1'b0, 8'hFE, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd2, 20'h01000, 1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 1'b0, 8'hFE, 8'h7F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{3'd4, 20'h00000, 1'b0, 9'h000, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00204, 1'b0, 8'hFF, 8'h7F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd4, 20'h00000, 1'b0, 9'h002, 1'b0, 1'b1, 1'b0, 1'b1, 20'h00108, 1'b1, 8'h00, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        '{3'd5, 20'h00000, 1'b0, 9'h1FF, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00FFC, 1'b0, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd2, 20'h02000, 1'b1, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 8'h00, 8'h7F, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd2, 20'h03000, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h00000, 1'b0, 8'h00, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd2, 20'h04000, 1'b0, 9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 1'b0, 8'h00, 8'h7D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        '{3'd5, 20'h00000, 1'b0, 9'h002, 1'b1, 1'b1, 1'b0, 1'b1, 20'h02000, 1'b1, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd3, 20'h0ABC0, 1'b1, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        '{3'd6, 20'h0ABC0, 1'b0, 9'h001, 1'b0, 1'b0, 1'b0, 1'b1, 20'h0ABC4, 1'b1, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{3'd7, 20'h00000, 1'b0, 9'h000, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00000, 1'b0, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_op = '0;
    logic [19:0] req_addr = '0;
    logic        req_local = 1'b0;
    logic [8:0]  req_imm = '0;
    logic        req_adjust = 1'b0;
    logic        req_wr_c = 1'b0;
    logic        req_wr_z = 1'b0;
    logic        ret_valid, ret_to_local, flag_c_we, flag_c, flag_z_we, flag_z, link_we;
    logic [19:0] ret_target, link_wdata;
    logic [8:0]  link_waddr;
    logic [7:0]  sp_a, sp_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rasx_dual_stack i_rasx_dual_stack (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_addr(req_addr),
        .req_local(req_local), .req_imm(req_imm), .req_adjust(req_adjust),
        .req_wr_c(req_wr_c), .req_wr_z(req_wr_z), .ret_valid(ret_valid),
        .ret_target(ret_target), .ret_to_local(ret_to_local),
        .flag_c_we(flag_c_we), .flag_c(flag_c), .flag_z_we(flag_z_we),
        .flag_z(flag_z), .link_we(link_we), .link_waddr(link_waddr),
        .link_wdata(link_wdata), .sp_a(sp_a), .sp_b(sp_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [19:0] addr, input logic loc,
                         input logic [8:0] imm, input logic adj, input logic wc, input logic wz);
        req_op = op; req_addr = addr; req_local = loc; req_imm = imm;
        req_adjust = adj; req_wr_c = wc; req_wr_z = wz;
    endtask

    task automatic check_reset();
        chk("R1 sp_a", 32'(sp_a), 32'h00);
        chk("R1 sp_b", 32'(sp_b), 32'h80);
        chk("R1 strobes", {28'd0, ret_valid, flag_c_we, flag_z_we, link_we}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;

        // table walk: R2..R11
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].op, VECS[i].addr, VECS[i].loc, VECS[i].imm,
                  VECS[i].adj, VECS[i].wc, VECS[i].wz);
            @(negedge clk);
            chk($sformatf("R2 R3 R4 R5 sp_a vec%0d", i), 32'(sp_a), 32'(VECS[i].spa));
            chk($sformatf("R2 R3 R4 R5 sp_b vec%0d", i), 32'(sp_b), 32'(VECS[i].spb));
            chk($sformatf("R4 R10 R11 ret_valid vec%0d", i), 32'(ret_valid), 32'(VECS[i].rv));
            if (VECS[i].rv) begin
                chk($sformatf("R4 R5 R10 target vec%0d", i), 32'(ret_target), 32'(VECS[i].tgt));
                chk($sformatf("R6 R10 to_local vec%0d", i), 32'(ret_to_local), 32'(VECS[i].eloc));
            end
            chk($sformatf("R7 c_we vec%0d", i), 32'(flag_c_we), 32'(VECS[i].cwe));
            if (VECS[i].cwe) chk($sformatf("R7 c vec%0d", i), 32'(flag_c), 32'(VECS[i].c));
            chk($sformatf("R8 z_we vec%0d", i), 32'(flag_z_we), 32'(VECS[i].zwe));
            if (VECS[i].zwe) chk($sformatf("R8 z vec%0d", i), 32'(flag_z), 32'(VECS[i].z));
            chk($sformatf("R9 R11 link_we vec%0d", i), 32'(link_we), 32'(VECS[i].lwe));
            if (VECS[i].lwe) begin
                chk("R9 link_waddr", 32'(link_waddr), 32'h1F0);
                chk("R9 link_wdata", 32'(link_wdata), 32'(VECS[i].addr));
            end
        end

        // R8: 128 pushes via A bring sp_a from 0 down onto sp_b=128
        for (int k = 0; k < 128; k++) begin
            drive(3'd1, 20'(k * 4), 1'b0, 9'h000, 1'b0, 1'b0, 1'b1);
            @(negedge clk);
            chk("R8 collision during A burst", 32'(flag_z), (k == 127) ? 32'd1 : 32'd0);
        end
        chk("R2 sp_a after burst", 32'(sp_a), 32'h80);

        // R5/R7/R8: adjust by +255 at sp_a=128 -> pops slot 127 (filled via B), wraps
        drive(3'd4, 20'h0, 1'b0, 9'h0FF, 1'b1, 1'b1, 1'b1);
        @(negedge clk);
        chk("R5 adjust target", 32'(ret_target), 32'h02000);
        chk("R6 adjust to_local", 32'(ret_to_local), 32'd1);
        chk("R5 adjust sp_a", 32'(sp_a), 32'h80);
        chk("R7 adjust wrap", 32'(flag_c), 32'd1);
        chk("R8 adjust collision", 32'(flag_z), 32'd1);

        // R7: flag_c holds when not requested
        drive(3'd1, 20'h0, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R7 c holds", {30'd0, flag_c_we, flag_c}, 32'd1);

        // R1: reset mid-run
        drive(3'd0, 20'h0, 1'b0, 9'h000, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule